// File: doc/BRIEF.md
# Pre-decoded Register-Execute-Memory-Writeback Pipeline

This block is the back half of a small in-order processor. Every clock cycle it takes one instruction that has already been decoded into fields. The fields are an operation code, two source register indices, a destination index, a 16-bit immediate, an operand-select code, a register write enable and memory controls. Operands come from an eight-entry, 16-bit register file, or from the immediate. Each instruction then passes through three pipeline registers: one holds the execute inputs, one holds the memory-stage inputs and one holds the writeback inputs. A result is written back into the register file and is also shown on a writeback observation port.

The pipeline has no interlock and no forwarding. Whatever supplies the instructions must space dependent instructions far enough apart, by inserting idle (no-operation) vectors. A small internal data memory of 32 sixteen-bit words serves store and load instructions. The register file and the memory have no reset. Only the enable bits of the pipeline are cleared by reset.

Top module: `rxw_datapath`

## Requirements
- R1: A synchronous active-high reset clears the write and memory enables held in all three stage registers. `wb_valid` is 0 while reset is applied and in the first cycle after it is released.
- R2: The operation codes 0, 1, 2 and 3 give the bitwise AND, the bitwise OR, the bitwise XOR and the sum of operand A and operand B. The sum wraps modulo 2^16.
- R3: Operation code 4 multiplies the low 8 bits of A by the low 8 bits of B as two's complement numbers and gives the 16-bit product. The upper bytes of the operands have no effect. Codes 5, 6 and 7 give a result of zero.
- R4: The operand-select code chooses where A and B come from. Code 0 takes A from register `src_a` and B from register `src_b`. Code 1 takes A from register `src_a` and B from the immediate. Code 2 makes A zero and takes B from the immediate. Code 3 takes A from the immediate and B from register `src_b`.
- R5: An instruction accepted at clock edge E appears on `wb_valid`/`wb_dst`/`wb_data` after edge E+2. The register file is updated at edge E+3.
- R6: A register read made in the same cycle as a writeback to that register returns the old value. A read made one cycle later returns the new value.
- R7: An instruction whose register write enable and memory enable are both 0 changes no register and no memory word, whatever its other fields hold. No writeback is shown for it.
- R8: A store (memory enable 1, memory write 1, register write enable 0) writes operand B to word `mem_addr`. A load to the same address issued in the very next cycle returns the stored value.
- R9: A load (memory enable 1, memory write 0, register write enable 1) writes the memory word at `mem_addr` to the destination register, in place of the ALU result.
- R10: Independent instructions issued back to back produce one writeback per cycle, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_op | input | 3 | Operation code (R2, R3) |
| in_opsel | input | 2 | Operand-select code (R4) |
| in_src_a | input | 3 | Register index for operand A |
| in_src_b | input | 3 | Register index for operand B and for store data |
| in_dst | input | 3 | Destination register index |
| in_imm | input | 16 | Immediate operand |
| in_reg_we | input | 1 | Register write enable |
| in_mem_en | input | 1 | Memory access enable |
| in_mem_wr | input | 1 | Access is a store (1) or a load (0) |
| in_mem_addr | input | 5 | Memory word address |
| wb_valid | output | 1 | A writeback happens this cycle |
| wb_dst | output | 3 | Register index being written |
| wb_data | output | 16 | Value being written |

## Verification
The first pattern loads every register with a distinct immediate. Register-to-register operations then run on values chosen so that a wrong operation code, a missing carry wrap, or a multiply that is unsigned or wider than a byte each gives a different number. The operand-select codes are tried with different registers on the A and B indices, so the writeback shows which register and which immediate were used. Two timed sequences check the pipeline timing. A read issued three cycles after a write, and another issued four cycles after it, show that there is no bypass and that the latency is correct. A store followed at once by a load shows the store-to-load ordering. Runs of idle vectors whose other fields are loaded with junk come last, and a full read-back of the registers and memory after them must match the reference model.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

   typedef enum logic [2:0] {
      OP_AND = 3'd0,
      OP_OR  = 3'd1,
      OP_XOR = 3'd2,
      OP_ADD = 3'd3,
      OP_MUL = 3'd4
   } op_e;

   typedef enum logic [1:0] {
      SEL_RR = 2'd0,
      SEL_RI = 2'd1,
      SEL_ZI = 2'd2,
      SEL_IR = 2'd3
   } opsel_e;

endpackage

// File: rtl/rxw_regfile.sv
module rxw_regfile #(
   parameter int DATA_W = 16,
   parameter int NREGS  = 8,
   localparam int AW    = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [AW-1:0]     raddr_a,
   input  logic [AW-1:0]     raddr_b,
   output logic [DATA_W-1:0] rdata_a,
   output logic [DATA_W-1:0] rdata_b,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata
);

   generate
      if (NREGS < 2 || (1 << AW) != NREGS) begin : g_bad_nregs
         $error("rxw_regfile: NREGS must be a power of two, at least 2");
      end
   endgenerate

   logic [NREGS-1:0][DATA_W-1:0] regs;

   // Write at the edge; reads are combinational and see the pre-edge value.
   always_ff @(posedge clk) begin
      if (we) regs[waddr] <= wdata;
   end

   assign rdata_a = regs[raddr_a];
   assign rdata_b = regs[raddr_b];

   AST_RF_HOLD: assert property (@(posedge clk) disable iff (rst)
      !we |=> $stable(regs)); // R7
   AST_RF_WRITE: assert property (@(posedge clk) disable iff (rst)
      we |=> regs[$past(waddr)] == $past(wdata)); // R5

endmodule

// File: rtl/rxw_alu.sv
module rxw_alu
   import rxw_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int MUL_W      = 8,
   parameter bit SIGNED_MUL = 1'b1
) (
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] res
);

   generate
      if (MUL_W < 1 || 2 * MUL_W > DATA_W) begin : g_bad_mulw
         $error("rxw_alu: product of two MUL_W operands must fit DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0] prod;

   // The multiplier variant is picked by parameter.
   generate
      if (SIGNED_MUL) begin : g_smul
         logic signed [2*MUL_W-1:0] p;
         assign p    = $signed(a[MUL_W-1:0]) * $signed(b[MUL_W-1:0]);
         assign prod = DATA_W'(p);
      end else begin : g_umul
         logic [2*MUL_W-1:0] p;
         assign p    = a[MUL_W-1:0] * b[MUL_W-1:0];
         assign prod = DATA_W'(p);
      end
   endgenerate

   always_comb begin
      case (op_e'(op))
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_ADD:  res = a + b;
         OP_MUL:  res = prod;
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/rxw_dmem.sv
module rxw_dmem #(
   parameter int DATA_W = 16,
   parameter int WORDS  = 32,
   localparam int AW    = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              wr,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   generate
      if (WORDS < 2 || (1 << AW) != WORDS) begin : g_bad_words
         $error("rxw_dmem: WORDS must be a power of two, at least 2");
      end
   endgenerate

   logic [WORDS-1:0][DATA_W-1:0] words;

   always_ff @(posedge clk) begin
      if (en && wr) words[addr] <= wdata;
   end

   assign rdata = words[addr];

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(en && wr) |=> $stable(words)); // R7
   AST_MEM_WRITE: assert property (@(posedge clk) disable iff (rst)
      (en && wr) |=> words[$past(addr)] == $past(wdata)); // R8

endmodule

// File: rtl/rxw_datapath.sv
module rxw_datapath
   import rxw_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int NREGS      = 8,
   parameter int MEM_WORDS  = 32,
   parameter int MUL_W      = 8,
   parameter bit SIGNED_MUL = 1'b1,
   localparam int RAW       = $clog2(NREGS),
   localparam int MAW       = $clog2(MEM_WORDS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        in_op,
   input  logic [1:0]        in_opsel,
   input  logic [RAW-1:0]    in_src_a,
   input  logic [RAW-1:0]    in_src_b,
   input  logic [RAW-1:0]    in_dst,
   input  logic [DATA_W-1:0] in_imm,
   input  logic              in_reg_we,
   input  logic              in_mem_en,
   input  logic              in_mem_wr,
   input  logic [MAW-1:0]    in_mem_addr,
   output logic              wb_valid,
   output logic [RAW-1:0]    wb_dst,
   output logic [DATA_W-1:0] wb_data
);

   // ---------------- register read and operand select ----------------
   logic [DATA_W-1:0] rd_a, rd_b, opa, opb;

   // stage 3 (writeback) state, declared early for the register file port
   logic              s3_we;
   logic [RAW-1:0]    s3_dst;
   logic [DATA_W-1:0] s3_data;

   rxw_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
      .clk     (clk),
      .rst     (rst),
      .raddr_a (in_src_a),
      .raddr_b (in_src_b),
      .rdata_a (rd_a),
      .rdata_b (rd_b),
      .we      (s3_we),
      .waddr   (s3_dst),
      .wdata   (s3_data)
   );

   always_comb begin
      case (opsel_e'(in_opsel))
         SEL_RR: begin opa = rd_a;   opb = rd_b;   end
         SEL_RI: begin opa = rd_a;   opb = in_imm; end
         SEL_ZI: begin opa = '0;     opb = in_imm; end
         SEL_IR: begin opa = in_imm; opb = rd_b;   end
      endcase
   end

   // ---------------- stage 1: execute inputs ----------------
   logic              s1_we, s1_men, s1_mwr;
   logic [2:0]        s1_op;
   logic [RAW-1:0]    s1_dst;
   logic [DATA_W-1:0] s1_a, s1_b;
   logic [MAW-1:0]    s1_addr;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_we  <= 1'b0;
         s1_men <= 1'b0;
         s1_mwr <= 1'b0;
      end else begin
         s1_we  <= in_reg_we;
         s1_men <= in_mem_en;
         s1_mwr <= in_mem_wr;
      end
   end

   always_ff @(posedge clk) begin
      s1_op   <= in_op;
      s1_dst  <= in_dst;
      s1_a    <= opa;
      s1_b    <= opb;
      s1_addr <= in_mem_addr;
   end

   logic [DATA_W-1:0] alu_res;

   rxw_alu #(.DATA_W(DATA_W), .MUL_W(MUL_W), .SIGNED_MUL(SIGNED_MUL)) u_alu (
      .op  (s1_op),
      .a   (s1_a),
      .b   (s1_b),
      .res (alu_res)
   );

   // ---------------- stage 2: memory inputs ----------------
   logic              s2_we, s2_men, s2_mwr;
   logic [RAW-1:0]    s2_dst;
   logic [DATA_W-1:0] s2_res, s2_st;
   logic [MAW-1:0]    s2_addr;

   always_ff @(posedge clk) begin
      if (rst) begin
         s2_we  <= 1'b0;
         s2_men <= 1'b0;
         s2_mwr <= 1'b0;
      end else begin
         s2_we  <= s1_we;
         s2_men <= s1_men;
         s2_mwr <= s1_mwr;
      end
   end

   always_ff @(posedge clk) begin
      s2_dst  <= s1_dst;
      s2_res  <= alu_res;
      s2_st   <= s1_b;
      s2_addr <= s1_addr;
   end

   logic [DATA_W-1:0] mem_rd;

   rxw_dmem #(.DATA_W(DATA_W), .WORDS(MEM_WORDS)) u_mem (
      .clk   (clk),
      .rst   (rst),
      .en    (s2_men),
      .wr    (s2_mwr),
      .addr  (s2_addr),
      .wdata (s2_st),
      .rdata (mem_rd)
   );

   logic is_load;
   assign is_load = s2_men && !s2_mwr;

   // ---------------- stage 3: writeback inputs ----------------
   always_ff @(posedge clk) begin
      if (rst) s3_we <= 1'b0;
      else     s3_we <= s2_we;
   end

   always_ff @(posedge clk) begin
      s3_dst  <= s2_dst;
      s3_data <= is_load ? mem_rd : s2_res;
   end

   assign wb_valid = s3_we;
   assign wb_dst   = s3_dst;
   assign wb_data  = s3_data;

   AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
      $past(rst) |-> !wb_valid); // R1
   AST_WB_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (rst)
      (in_reg_we == 1'b0) |=> ##2 !wb_valid); // R7

endmodule

// File: tb/sim_rxw_datapath.sv
`timescale 1ns/1ps
module sim_rxw_datapath;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  in_op = '0;
   logic [1:0]  in_opsel = '0;
   logic [2:0]  in_src_a = '0, in_src_b = '0, in_dst = '0;
   logic [15:0] in_imm = '0;
   logic        in_reg_we = 1'b0, in_mem_en = 1'b0, in_mem_wr = 1'b0;
   logic [4:0]  in_mem_addr = '0;
   logic        wb_valid;
   logic [2:0]  wb_dst;
   logic [15:0] wb_data;
   int          cur_tag = 1;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   rxw_datapath u0 (
      .clk(clk), .rst(rst), .in_op(in_op), .in_opsel(in_opsel),
      .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
      .in_imm(in_imm), .in_reg_we(in_reg_we), .in_mem_en(in_mem_en),
      .in_mem_wr(in_mem_wr), .in_mem_addr(in_mem_addr),
      .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_data(wb_data)
   );

   // ---------------- behavioural reference model ----------------
   typedef struct {
      bit          we;
      bit          men;
      bit          mwr;
      logic [15:0] b;
      logic [2:0]  dst;
      logic [4:0]  addr;
      logic [15:0] data;
      int          tag;
   } rec_t;

   logic [15:0] mrf  [8];
   logic [15:0] mmem [32];
   rec_t        p1, p2, p3;

   function automatic logic [15:0] ref_alu(input logic [2:0] op,
                                           input logic [15:0] a, input logic [15:0] b);
      int sa, sb, pr;
      case (op)
         3'd0: return a & b;
         3'd1: return a | b;
         3'd2: return a ^ b;
         3'd3: return 16'((32'(a) + 32'(b)) % 65536);
         3'd4: begin
            sa = int'($signed(a[7:0]));
            sb = int'($signed(b[7:0]));
            pr = sa * sb;
            return pr[15:0];
         end
         default: return 16'h0000;
      endcase
   endfunction

   always @(posedge clk) begin
      rec_t n;
      logic [15:0] a, b;
      if (rst) begin
         p1.we = 0; p1.men = 0; p2.we = 0; p2.men = 0; p3.we = 0; p3.men = 0;
      end else begin
         case (in_opsel)
            2'd0: begin a = mrf[in_src_a]; b = mrf[in_src_b]; end
            2'd1: begin a = mrf[in_src_a]; b = in_imm; end
            2'd2: begin a = 16'h0;         b = in_imm; end
            default: begin a = in_imm;     b = mrf[in_src_b]; end
         endcase
         n.we = in_reg_we; n.men = in_mem_en; n.mwr = in_mem_wr;
         n.b = b; n.dst = in_dst; n.addr = in_mem_addr;
         n.data = ref_alu(in_op, a, b); n.tag = cur_tag;
         if (p2.men && p2.mwr)  mmem[p2.addr] = p2.b;
         else if (p2.men)       p2.data = mmem[p2.addr];
         if (p3.we) mrf[p3.dst] = p3.data;
         p3 = p2; p2 = p1; p1 = n;
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         if (rst) begin
            checks++;
            if (wb_valid !== 1'b0) begin
               errors++;
               $display("FAIL R1 wb_valid in reset actual=%b expected=0", wb_valid);
            end
         end else begin
            checks++;
            if (wb_valid !== p3.we) begin
               errors++;
               $display("FAIL R%0d wb_valid actual=%b expected=%b", p3.tag, wb_valid, p3.we);
            end else if (p3.we && (wb_dst !== p3.dst || wb_data !== p3.data)) begin
               errors++;
               $display("FAIL R%0d writeback actual=r%0d:%h expected=r%0d:%h",
                        p3.tag, wb_dst, wb_data, p3.dst, p3.data);
            end
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic issue(input logic [2:0] op, input logic [1:0] sel,
                        input logic [2:0] sa, input logic [2:0] sb, input logic [2:0] d,
                        input logic [15:0] imm, input bit we, input bit men, input bit mwr,
                        input logic [4:0] addr, input int tag);
      in_op = op; in_opsel = sel; in_src_a = sa; in_src_b = sb; in_dst = d;
      in_imm = imm; in_reg_we = we; in_mem_en = men; in_mem_wr = mwr;
      in_mem_addr = addr; cur_tag = tag;
      @(negedge clk);
   endtask

   task automatic nop(input int n, input int tag);
      for (int i = 0; i < n; i++)
         issue(3'd3, 2'd2, 3'd7, 3'd6, 3'(i), 16'hDEAD, 1'b0, 1'b0, 1'b1, 5'(i), tag);
   endtask

   task automatic mov(input logic [2:0] d, input logic [15:0] v, input int tag);
      issue(3'd3, 2'd2, 3'd0, 3'd0, d, v, 1'b1, 1'b0, 1'b0, 5'd0, tag);
   endtask

   initial begin
      repeat (4) @(negedge clk);           // R1 checked during reset
      rst = 1'b0;
      @(negedge clk);                      // R1 first cycle after release

      // R4 / R10: fill registers back to back with immediates
      mov(3'd0, 16'h00F0, 10); mov(3'd1, 16'h0005, 10);
      mov(3'd2, 16'hFFF0, 10); mov(3'd3, 16'h0020, 10);
      mov(3'd4, 16'h12FE, 10); mov(3'd5, 16'h3403, 10);
      mov(3'd6, 16'hA5A5, 10); mov(3'd7, 16'h0F0F, 10);
      nop(3, 7);

      // R2: logic ops and a wrapping add
      issue(3'd0, 2'd0, 3'd6, 3'd7, 3'd0, 16'h0, 1, 0, 0, 5'd0, 2);
      issue(3'd1, 2'd0, 3'd6, 3'd7, 3'd1, 16'h0, 1, 0, 0, 5'd0, 2);
      issue(3'd2, 2'd0, 3'd6, 3'd7, 3'd6, 16'h0, 1, 0, 0, 5'd0, 2);
      issue(3'd3, 2'd0, 3'd2, 3'd3, 3'd7, 16'h0, 1, 0, 0, 5'd0, 2);
      // R3: signed byte multiply, upper bytes ignored, reserved codes
      nop(3, 7);
      mov(3'd0, 16'h00F0, 10); mov(3'd1, 16'h0005, 10);
      nop(3, 7);
      issue(3'd4, 2'd0, 3'd0, 3'd1, 3'd2, 16'h0, 1, 0, 0, 5'd0, 3);
      issue(3'd4, 2'd0, 3'd4, 3'd5, 3'd3, 16'h0, 1, 0, 0, 5'd0, 3);
      issue(3'd4, 2'd1, 3'd0, 3'd0, 3'd6, 16'hFF80, 1, 0, 0, 5'd0, 3);
      issue(3'd5, 2'd0, 3'd4, 3'd5, 3'd7, 16'h0, 1, 0, 0, 5'd0, 3);
      issue(3'd6, 2'd1, 3'd4, 3'd5, 3'd7, 16'hFFFF, 1, 0, 0, 5'd0, 3);
      issue(3'd7, 2'd3, 3'd4, 3'd5, 3'd7, 16'hFFFF, 1, 0, 0, 5'd0, 3);
      nop(3, 7);

      // R4: select codes with distinct A and B registers
      issue(3'd1, 2'd1, 3'd4, 3'd5, 3'd0, 16'h8000, 1, 0, 0, 5'd0, 4);
      issue(3'd1, 2'd3, 3'd4, 3'd5, 3'd1, 16'h8000, 1, 0, 0, 5'd0, 4);
      issue(3'd2, 2'd2, 3'd4, 3'd5, 3'd6, 16'h5A5A, 1, 0, 0, 5'd0, 4);
      nop(3, 7);

      // R6 / R5: read at the writeback cycle sees old, one later sees new
      mov(3'd2, 16'h1111, 5);
      nop(2, 7);
      issue(3'd1, 2'd1, 3'd2, 3'd0, 3'd3, 16'h0, 1, 0, 0, 5'd0, 6);
      issue(3'd1, 2'd1, 3'd2, 3'd0, 3'd4, 16'h0, 1, 0, 0, 5'd0, 6);
      nop(3, 7);

      // R8 / R9: stores then immediate loads
      issue(3'd3, 2'd2, 3'd0, 3'd0, 3'd0, 16'hBEEF, 0, 1, 1, 5'd5, 8);
      issue(3'd3, 2'd2, 3'd0, 3'd0, 3'd5, 16'h0, 1, 1, 0, 5'd5, 8);
      issue(3'd3, 2'd0, 3'd0, 3'd6, 3'd0, 16'h0, 0, 1, 1, 5'd31, 8);
      issue(3'd3, 2'd0, 3'd0, 3'd0, 3'd7, 16'h0, 1, 1, 0, 5'd31, 9);
      issue(3'd3, 2'd2, 3'd0, 3'd0, 3'd0, 16'h7777, 0, 1, 1, 5'd0, 8);
      nop(3, 7);

      // R7: junk-filled idle vectors, then read everything back
      for (int i = 0; i < 6; i++)
         issue(3'(i), 2'(i), 3'(i), 3'(7 - i), 3'(i), 16'hFFFF, 0, 0, 1, 5'(i * 5), 7);
      nop(3, 7);
      for (int r = 0; r < 8; r++)
         issue(3'd1, 2'd1, 3'(r), 3'd0, 3'(r), 16'h0, 1, 0, 0, 5'd0, 7);
      issue(3'd0, 2'd0, 3'd0, 3'd0, 3'd1, 16'h0, 1, 1, 0, 5'd5, 7);
      issue(3'd0, 2'd0, 3'd0, 3'd0, 3'd2, 16'h0, 1, 1, 0, 5'd31, 7);
      issue(3'd0, 2'd0, 3'd0, 3'd0, 3'd3, 16'h0, 1, 1, 0, 5'd0, 7);
      nop(5, 7);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL R10 watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule